// File: doc/BRIEF.md
# Register-File Watchpoint Break Unit

This block monitors the register-file access bus of a processor core and asks the debug logic to halt the core when a chosen access happens. Software programs three 8-bit registers through a small write port: a control register, a low-address register and a watch-data register. The control register holds the read and write enables, a data-compare qualifier, and the top four bits of the 12-bit watched address.

For every read or write strobe whose address equals the programmed address, the block raises a break request. The access must be of an enabled kind. When the data-compare qualifier is set, the data on the bus must also equal the watch-data value. The request is a registered pulse, one clock long.

A read-protect input stops the enable and qualifier bits from being set. The address nibble in the same register can still be written while protection is active.

Top module: `wpt_break_unit`

## Requirements
- R1: After reset all three registers read 0 and `brk_o` is 0.
- R2: The port `cfg_sel` picks the register for writes and for readback on `cfg_rdata`: 0 = control, 1 = low address, 2 = watch data, 3 = none (writes are dropped and readback is 0). Control bit 4 always reads 0.
- R3: With control bit 7 (write enable) set, a write strobe whose address equals the watched address makes `brk_o` 1 in the next cycle only, as a single-cycle pulse.
- R4: With control bit 6 (read enable) set, a read strobe whose address equals the watched address makes `brk_o` 1 in the next cycle.
- R5: A strobe whose matching enable is clear produces no break.
- R6: With control bit 5 (data compare) set, a break occurs only when `rf_data` equals the watch-data register.
- R7: Control bit 5 alone, with bits 7 and 6 clear, never produces a break.
- R8: While `rprot_i` is 1, a control write stores 0 into bits 7:5 and still stores bits 3:0.
- R9: The watched address is {control[3:0], low-address[7:0]}. A difference in either part gives no break.
- R10: A read strobe and a write strobe that both hit in the same cycle give one break pulse, one cycle long.
- R11: A register write takes effect for accesses from the next cycle on. An access in the same cycle as the write is judged against the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and readback |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| rprot_i | input | 1 | Read-protect lock |
| rf_addr | input | 12 | Register-file access address |
| rf_data | input | 8 | Register-file read or write data |
| rf_rd | input | 1 | Register-file read strobe |
| rf_wr | input | 1 | Register-file write strobe |
| brk_o | output | 1 | Break request pulse |

## Verification
The bench aims at five corner cases.

- Addresses that differ from the watched one only in the upper nibble, or only in the low byte. A design that compared only part of the address would raise false breaks on these.
- Control writes that try to set the enables under read protection. A lock that also froze the nibble, or that let a bit through, shows up on readback and in later hits.
- Data-compare cases: the qualifier alone with no enable, and bus data one off from the watch data. These catch a qualifier that acts as an enable, and an equality test that is loose.
- Simultaneous read and write hits. These must give exactly one single-cycle pulse, not a stretched one.
- Random traffic that mixes register writes with accesses in the same cycle. This exposes a design that applies new settings one cycle early.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int WPT_ADDR_W = 12;
  localparam int WPT_DATA_W = 8;
  localparam int BIT_WR  = 7;
  localparam int BIT_RD  = 6;
  localparam int BIT_DM  = 5;
  localparam int BIT_RSV = 4;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_WDAT = 2'd2,
    SEL_NONE = 2'd3
  } wpt_sel_e;
endpackage

// File: rtl/wpt_rst_sync.sv
module wpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/wpt_regs.sv
module wpt_regs
  import wpt_pkg::*;
#(
  parameter int DATA_W = WPT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              rprot_i,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] alo_q,
  output logic [DATA_W-1:0] wdat_q,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic [DATA_W-1:0] ctrl_d, alo_d, wdat_d;
  logic              ctrl_en, alo_en, wdat_en;
  logic [DATA_W-1:0] lock_mask;

  always_comb begin
    ctrl_en = cfg_we && (cfg_sel == SEL_CTRL);
    alo_en  = cfg_we && (cfg_sel == SEL_ALO);
    wdat_en = cfg_we && (cfg_sel == SEL_WDAT);
    lock_mask = '1;
    lock_mask[BIT_RSV] = 1'b0;
    if (rprot_i) begin
      lock_mask[BIT_WR] = 1'b0;
      lock_mask[BIT_RD] = 1'b0;
      lock_mask[BIT_DM] = 1'b0;
    end
    ctrl_d = ctrl_en ? (cfg_wdata & lock_mask) : ctrl_q;
    alo_d  = alo_en  ? cfg_wdata : alo_q;
    wdat_d = wdat_en ? cfg_wdata : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      alo_q  <= '0;
      wdat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      alo_q  <= alo_d;
      wdat_q <= wdat_d;
    end
  end

  always_comb begin
    unique case (cfg_sel)
      SEL_CTRL: cfg_rdata = ctrl_q;
      SEL_ALO:  cfg_rdata = alo_q;
      SEL_WDAT: cfg_rdata = wdat_q;
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wpt_match.sv
module wpt_match #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic                     en_wr,
  input  logic                     en_rd,
  input  logic                     en_dm,
  input  logic [ADDR_W-DATA_W-1:0] addr_hi,
  input  logic [DATA_W-1:0]        addr_lo,
  input  logic [DATA_W-1:0]        wdat,
  input  logic [ADDR_W-1:0]        rf_addr,
  input  logic [DATA_W-1:0]        rf_data,
  input  logic                     rf_rd,
  input  logic                     rf_wr,
  output logic                     hit
);
  localparam int NCH = 2;
  logic [ADDR_W-1:0] watch_addr;
  logic              addr_eq, data_ok;
  logic [NCH-1:0]    ch_strobe, ch_en, ch_hit;

  always_comb begin
    watch_addr = {addr_hi, addr_lo};
    addr_eq    = (rf_addr == watch_addr);
    data_ok    = !en_dm || (rf_data == wdat);
    ch_strobe  = {rf_wr, rf_rd};
    ch_en      = {en_wr, en_rd};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_hit[g] = ch_strobe[g] && ch_en[g] && addr_eq && data_ok;
  end

  assign hit = |ch_hit;
endmodule

// File: rtl/wpt_break_unit.sv
module wpt_break_unit
  import wpt_pkg::*;
#(
  parameter int ADDR_W = WPT_ADDR_W,
  parameter int DATA_W = WPT_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              rprot_i,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              rf_rd,
  input  logic              rf_wr,
  output logic              brk_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              rst_s;
  logic [DATA_W-1:0] ctrl_q, alo_q, wdat_q;
  logic              hit;
  logic              brk_d, brk_q;

  wpt_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  wpt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_s     (rst_s),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rprot_i   (rprot_i),
    .ctrl_q    (ctrl_q),
    .alo_q     (alo_q),
    .wdat_q    (wdat_q),
    .cfg_rdata (cfg_rdata)
  );

  wpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .en_wr   (ctrl_q[BIT_WR]),
    .en_rd   (ctrl_q[BIT_RD]),
    .en_dm   (ctrl_q[BIT_DM]),
    .addr_hi (ctrl_q[HI_W-1:0]),
    .addr_lo (alo_q),
    .wdat    (wdat_q),
    .rf_addr (rf_addr),
    .rf_data (rf_data),
    .rf_rd   (rf_rd),
    .rf_wr   (rf_wr),
    .hit     (hit)
  );

  always_comb brk_d = hit;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) brk_q <= 1'b0;
    else        brk_q <= brk_d;
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/wpt_break_chk.sv
module wpt_break_chk
  import wpt_pkg::*;
#(
  parameter int ADDR_W = WPT_ADDR_W,
  parameter int DATA_W = WPT_DATA_W
) (
  input logic              clk,
  input logic              rst_s,
  input logic              cfg_we,
  input logic [1:0]        cfg_sel,
  input logic              rprot_i,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] alo_q,
  input logic [DATA_W-1:0] wdat_q,
  input logic [ADDR_W-1:0] rf_addr,
  input logic [DATA_W-1:0] rf_data,
  input logic              rf_rd,
  input logic              rf_wr,
  input logic              brk_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  logic at_watch;
  assign at_watch = (rf_addr == {ctrl_q[HI_W-1:0], alo_q});

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ctrl_q[BIT_RSV] == 1'b0);

  // R3
  wr_hit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rf_wr && ctrl_q[BIT_WR] && at_watch && (!ctrl_q[BIT_DM] || rf_data == wdat_q))
    |=> brk_o);

  // R5
  idle_nobrk_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!rf_rd && !rf_wr) |=> !brk_o);

  // R7
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!ctrl_q[BIT_WR] && !ctrl_q[BIT_RD]) |=> !brk_o);

  // R8
  lock_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rprot_i && cfg_we && cfg_sel == SEL_CTRL)
    |=> (!ctrl_q[BIT_WR] && !ctrl_q[BIT_RD] && !ctrl_q[BIT_DM]));
endmodule

bind wpt_break_unit wpt_break_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .cfg_we  (cfg_we),
  .cfg_sel (cfg_sel),
  .rprot_i (rprot_i),
  .ctrl_q  (ctrl_q),
  .alo_q   (alo_q),
  .wdat_q  (wdat_q),
  .rf_addr (rf_addr),
  .rf_data (rf_data),
  .rf_rd   (rf_rd),
  .rf_wr   (rf_wr),
  .brk_o   (brk_o)
);

// File: tb/sim_wpt_break_unit.sv
`timescale 1ns/1ps
module sim_wpt_break_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        rprot_i;
  logic [11:0] rf_addr;
  logic [7:0]  rf_data;
  logic        rf_rd, rf_wr;
  logic        brk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_ctrl, m_alo, m_wdat;

  always #2.5 clk = ~clk;

  wpt_break_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rprot_i(rprot_i),
    .rf_addr(rf_addr), .rf_data(rf_data), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .brk_o(brk_o)
  );

  function automatic logic hit_of(input logic en, input logic strobe,
                                  input logic [11:0] a, input logic [7:0] d);
    return strobe && en && (a == {m_ctrl[3:0], m_alo}) &&
           (!m_ctrl[5] || d == m_wdat);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, then check brk_o after the capturing edge
  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] wd,
                      input logic rp, input logic rd, input logic wr,
                      input logic [11:0] a, input logic [7:0] d, input string req);
    logic hr, hw, exp;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd; rprot_i = rp;
    rf_rd = rd; rf_wr = wr; rf_addr = a; rf_data = d;
    hr  = hit_of(m_ctrl[6], rd, a, d);
    hw  = hit_of(m_ctrl[7], wr, a, d);
    exp = hr | hw;  // R11: judged on old settings
    if (we) begin
      case (sel)
        2'd0: m_ctrl = {wd[7:5] & {3{~rp}}, 1'b0, wd[3:0]};
        2'd1: m_alo  = wd;
        2'd2: m_wdat = wd;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    check(req, {7'd0, brk_o}, {7'd0, exp});
  endtask

  task automatic idle(input string req);
    step(0, 2'd3, 8'h00, rprot_i, 0, 0, 12'h000, 8'h00, req);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [7:0] v, input logic rp);
    step(1, sel, v, rp, 0, 0, 12'h000, 8'h00, "R11");
  endtask

  task automatic rdchk(input logic [1:0] sel, input logic [7:0] exp, input string req);
    cfg_we = 0; cfg_sel = sel; #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; rprot_i = 0;
    rf_addr = 0; rf_data = 0; rf_rd = 0; rf_wr = 0;
    m_ctrl = 0; m_alo = 0; m_wdat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1
    rdchk(2'd0, 8'h00, "R1"); rdchk(2'd1, 8'h00, "R1"); rdchk(2'd2, 8'h00, "R1");
    check("R1", {7'd0, brk_o}, 8'h00);

    // R2
    wreg(2'd0, 8'hFF, 0);
    rdchk(2'd0, 8'hEF, "R2");
    wreg(2'd3, 8'hAA, 0);
    rdchk(2'd3, 8'h00, "R2");
    rdchk(2'd1, 8'h00, "R2");

    // R3 / R9 / R5
    wreg(2'd1, 8'h34, 0);
    wreg(2'd0, 8'h82, 0);
    step(0, 2'd3, 0, 0, 0, 1, 12'h234, 8'h11, "R3");
    idle("R3");
    step(0, 2'd3, 0, 0, 1, 0, 12'h234, 8'h11, "R5");
    step(0, 2'd3, 0, 0, 0, 1, 12'h334, 8'h11, "R9");
    step(0, 2'd3, 0, 0, 0, 1, 12'h235, 8'h11, "R9");

    // R4
    wreg(2'd0, 8'h42, 0);
    step(0, 2'd3, 0, 0, 1, 0, 12'h234, 8'h00, "R4");
    step(0, 2'd3, 0, 0, 0, 1, 12'h234, 8'h00, "R5");

    // R6
    wreg(2'd2, 8'h5A, 0);
    wreg(2'd0, 8'hE2, 0);
    step(0, 2'd3, 0, 0, 0, 1, 12'h234, 8'h5A, "R6");
    step(0, 2'd3, 0, 0, 0, 1, 12'h234, 8'h5B, "R6");
    step(0, 2'd3, 0, 0, 1, 0, 12'h234, 8'h5A, "R6");

    // R7
    wreg(2'd0, 8'h22, 0);
    step(0, 2'd3, 0, 0, 1, 1, 12'h234, 8'h5A, "R7");

    // R10
    wreg(2'd0, 8'hC2, 0);
    step(0, 2'd3, 0, 0, 1, 1, 12'h234, 8'h00, "R10");
    idle("R10");

    // R11: write in the same cycle as a hitting access
    step(1, 2'd0, 8'h02, 0, 0, 1, 12'h234, 8'h00, "R11");
    step(0, 2'd3, 0, 0, 0, 1, 12'h234, 8'h00, "R11");

    // R8
    wreg(2'd0, 8'hE7, 1);
    rdchk(2'd0, 8'h07, "R8");
    step(0, 2'd3, 0, 1, 1, 1, 12'h734, 8'h5A, "R8");
    rprot_i = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic we, rp, rd, wr;
      logic [1:0] sel;
      logic [7:0] wd, d;
      logic [11:0] a;
      we  = ($urandom % 6) == 0;
      sel = 2'($urandom % 4);
      wd  = 8'($urandom);
      if (sel == 2'd1) wd = {4'h3, wd[3:0]};
      rp  = ($urandom % 8) == 0;
      rd  = $urandom % 2;
      wr  = $urandom % 3 == 0;
      a   = ($urandom % 2) ? {m_ctrl[3:0], m_alo} : 12'($urandom);
      if ($urandom % 4 == 0) a[0] = ~a[0];
      d   = ($urandom % 2) ? m_wdat : 8'($urandom);
      step(we, sel, wd, rp, rd, wr, a, d, "R3 R4 R6 R9 random");
    end
    rdchk(2'd0, m_ctrl, "R2");
    rdchk(2'd1, m_alo, "R2");
    rdchk(2'd2, m_wdat, "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule